// File: doc/BRIEF.md
# Track Half-Bit Timing Receiver

This block takes a two-level track signal that has already been cleaned up and turned into a logic input. It turns that signal into a stream of decoded bits. The signal is first passed through a short synchroniser. After that, every transition, rising or falling, closes one interval and opens the next. Each interval is timed in whole microseconds. The time base is a divided-down tick derived from the system clock, and the count stops at its top value instead of wrapping. At the edge that closes it, each interval is classed as a short half (half "1"), a long half (half "0"), or unusable.

A pairing stage then joins consecutive halves into bits:
- Two matching halves produce a one-cycle `bit_valid` strobe, with `bit_value` telling which kind of bit it was.
- An unusable interval produces a one-cycle `err_pulse`, which tells the packet layer to throw away the message it is assembling. A line that stays at one level for too long does the same.
- Two disagreeing halves inside a locked bit stream also produce `err_pulse`.

After any fault the pairing stage hunts quietly until it sees two matching valid halves. It then locks again. Long halves are never stretched, so a long "0" counts as a fault.

Top module: `track_halfbit_rx`

## Requirements
- R1: Both rising and falling transitions of `track_in` end one interval and start the next. The synchroniser delay is the same for every edge, so interval lengths are kept exactly.
- R2: An interval of 52 to 64 µs, both limits included, is a half "1". Intervals of 51 µs and 65 µs are not.
- R3: An interval of 95 to 200 µs, both limits included, is a half "0". An interval of 94 µs is not.
- R4: An interval that fits neither class raises `err_pulse` for one cycle and sends the pairing stage back to hunting. Such intervals include glitches of a few µs and intervals that fall between the two windows.
- R5: Two consecutive matching halves give exactly one `bit_valid` pulse of one cycle. `bit_value` is 1 for two half "1"s and 0 for two half "0"s. A lone trailing half gives no bit.
- R6: While locked, a second half that disagrees with the first raises `err_pulse`. That second half is then kept as the first half of a new candidate bit.
- R7: While hunting, a disagreeing half raises no error. It simply replaces the candidate half.
- R8: An interval that reaches 201 µs without an edge raises one `err_pulse` at that moment. The edge that finally ends it raises no further error and leaves the stage hunting.
- R9: The interval count saturates. A gap far longer than the count range, for example 400 µs, is never taken as a valid half.
- R10: During reset and right after it, `bit_valid` and `err_pulse` stay low, and the pairing stage starts out hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| track_in | input | 1 | Conditioned track level, asynchronous to `clk` |
| bit_valid | output | 1 | One-cycle strobe: a complete bit was received |
| bit_value | output | 1 | Value of the bit, valid while `bit_valid` is high |
| err_pulse | output | 1 | One-cycle strobe: discard the current message |

## Verification
The hardest states to reach from the ports are those that depend on long silences and on the pairing history. Examples are a saturated counter whose raw value would otherwise wrap into the "0" window, and the difference between a mismatch while locked and a mismatch while hunting. The stimulus reaches them with per-vector half sequences:
- a 400 µs gap followed by halves whose decoding would change if the count had wrapped;
- a 250 µs hold and an exactly 201 µs hold;
- sequences that lock first and then break a pair, or that break a pair before any lock.

Every vector ends with an idle hold longer than the timeout. This returns the block to hunting in a known way, so each vector's bits and errors can be counted on their own.

// File: rtl/thr_pkg.sv
package thr_pkg;

    typedef enum logic [1:0] {
        HK_ONE  = 2'd0,
        HK_ZERO = 2'd1,
        HK_BAD  = 2'd2,
        HK_SKIP = 2'd3
    } half_kind_e;

    typedef enum logic [1:0] {
        PS_HUNT_EMPTY = 2'd0,
        PS_HUNT_HAVE  = 2'd1,
        PS_SYNC_EMPTY = 2'd2,
        PS_SYNC_HAVE  = 2'd3
    } pair_state_e;

endpackage

// File: rtl/thr_sync_edge.sv
module thr_sync_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic edge_seen
);
    localparam int unsigned MSB = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[SYNC_STAGES-2:0], din};
        st_d.prev  = st_q.chain[MSB];
        edge_seen  = st_q.chain[MSB] ^ st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    initial assert (SYNC_STAGES >= 2) else $error("sync chain too short");

endmodule

// File: rtl/thr_us_tick.sv
module thr_us_tick #(
    parameter int unsigned CLK_PER_US = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int unsigned DIV_W = (CLK_PER_US > 2) ? $clog2(CLK_PER_US) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(CLK_PER_US - 1);

    logic [DIV_W-1:0] div_d, div_q;

    always_comb begin
        tick = (div_q == LAST);
        if (restart)   div_d = DIV_W'(1);
        else if (tick) div_d = '0;
        else           div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // R1: the divider is realigned by every edge, so an edge is followed by a full period
    assert_restart_aligns_R1: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (div_q == DIV_W'(1)));

    initial assert (CLK_PER_US >= 2) else $error("tick divider needs at least 2 clocks");

endmodule

// File: rtl/thr_interval_timer.sv
module thr_interval_timer
    import thr_pkg::*;
#(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned ONE_MIN  = 52,
    parameter int unsigned ONE_MAX  = 64,
    parameter int unsigned ZERO_MIN = 95,
    parameter int unsigned ZERO_MAX = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       edge_seen,
    input  logic       tick,
    output logic       half_stb,
    output half_kind_e half_kind
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE_LO  = CNT_W'(ONE_MIN);
    localparam logic [CNT_W-1:0] ONE_HI  = CNT_W'(ONE_MAX);
    localparam logic [CNT_W-1:0] ZERO_LO = CNT_W'(ZERO_MIN);
    localparam logic [CNT_W-1:0] ZERO_HI = CNT_W'(ZERO_MAX);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             half_stb;
        half_kind_e       half_kind;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.half_stb = 1'b0;
        if (edge_seen) begin
            st_d.count    = '0;
            st_d.half_stb = 1'b1;
            if (st_q.count > ZERO_HI)
                st_d.half_kind = HK_SKIP;
            else if (st_q.count >= ONE_LO && st_q.count <= ONE_HI)
                st_d.half_kind = HK_ONE;
            else if (st_q.count >= ZERO_LO)
                st_d.half_kind = HK_ZERO;
            else
                st_d.half_kind = HK_BAD;
        end else if (tick) begin
            if (st_q.count != CNT_MAX) st_d.count = st_q.count + 1'b1;
            if (st_q.count == ZERO_HI) begin
                st_d.half_stb  = 1'b1;
                st_d.half_kind = HK_BAD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{count: '0, half_stb: 1'b0, half_kind: HK_SKIP};
        else        st_q <= st_d;
    end

    assign half_stb  = st_q.half_stb;
    assign half_kind = st_q.half_kind;

    assert_one_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (half_stb && half_kind == HK_ONE) |->
            ($past(st_q.count) >= ONE_LO && $past(st_q.count) <= ONE_HI));

    assert_zero_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (half_stb && half_kind == HK_ZERO) |->
            ($past(st_q.count) >= ZERO_LO && $past(st_q.count) <= ZERO_HI));

    assert_skip_after_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (half_stb && half_kind == HK_SKIP) |-> ($past(st_q.count) > ZERO_HI));

    assert_count_saturates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.count == CNT_MAX && !edge_seen) |=> (st_q.count == CNT_MAX));

    initial assert (ZERO_MAX < (2 ** CNT_W) - 1 && ONE_MAX < ZERO_MIN && ONE_MIN <= ONE_MAX)
        else $error("inconsistent interval windows");

endmodule

// File: rtl/thr_half_pairer.sv
module thr_half_pairer
    import thr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       half_stb,
    input  half_kind_e half_kind,
    output logic       bit_valid,
    output logic       bit_value,
    output logic       err_pulse
);
    typedef struct packed {
        pair_state_e state;
        logic        pend;
        logic        bit_valid;
        logic        bit_value;
        logic        err;
    } pair_st_t;

    pair_st_t st_d, st_q;
    logic     kind_bit;
    logic     is_half;

    always_comb begin
        st_d           = st_q;
        st_d.bit_valid = 1'b0;
        st_d.err       = 1'b0;
        kind_bit       = (half_kind == HK_ONE);
        is_half        = (half_kind == HK_ONE) || (half_kind == HK_ZERO);
        if (half_stb) begin
            if (!is_half) begin
                st_d.state = PS_HUNT_EMPTY;
                st_d.err   = (half_kind == HK_BAD);
            end else begin
                unique case (st_q.state)
                    PS_HUNT_EMPTY: begin
                        st_d.state = PS_HUNT_HAVE;
                        st_d.pend  = kind_bit;
                    end
                    PS_HUNT_HAVE: begin
                        if (kind_bit == st_q.pend) begin
                            st_d.state     = PS_SYNC_EMPTY;
                            st_d.bit_valid = 1'b1;
                            st_d.bit_value = kind_bit;
                        end else begin
                            st_d.pend = kind_bit;
                        end
                    end
                    PS_SYNC_EMPTY: begin
                        st_d.state = PS_SYNC_HAVE;
                        st_d.pend  = kind_bit;
                    end
                    PS_SYNC_HAVE: begin
                        if (kind_bit == st_q.pend) begin
                            st_d.state     = PS_SYNC_EMPTY;
                            st_d.bit_valid = 1'b1;
                            st_d.bit_value = kind_bit;
                        end else begin
                            st_d.state = PS_HUNT_HAVE;
                            st_d.pend  = kind_bit;
                            st_d.err   = 1'b1;
                        end
                    end
                    default: st_d.state = PS_HUNT_EMPTY;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: PS_HUNT_EMPTY, pend: 1'b0, bit_valid: 1'b0,
                               bit_value: 1'b0, err: 1'b0};
        else        st_q <= st_d;
    end

    assign bit_valid = st_q.bit_valid;
    assign bit_value = st_q.bit_value;
    assign err_pulse = st_q.err;

    assert_bit_from_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> ($past(half_stb) && $past(half_kind) != HK_BAD));

    assert_err_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> ($past(half_stb) && $past(half_kind) != HK_SKIP));

    assert_sync_mismatch_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (half_stb && st_q.state == PS_SYNC_HAVE && is_half && kind_bit != st_q.pend)
            |=> (err_pulse && st_q.state == PS_HUNT_HAVE));

    assert_hunt_mismatch_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (half_stb && st_q.state == PS_HUNT_HAVE && is_half && kind_bit != st_q.pend)
            |=> !err_pulse);

endmodule

// File: rtl/track_halfbit_rx.sv
module track_halfbit_rx
    import thr_pkg::*;
#(
    parameter int unsigned CLK_PER_US  = 100,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned ONE_MIN     = 52,
    parameter int unsigned ONE_MAX     = 64,
    parameter int unsigned ZERO_MIN    = 95,
    parameter int unsigned ZERO_MAX    = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic track_in,
    output logic bit_valid,
    output logic bit_value,
    output logic err_pulse
);
    logic       edge_seen;
    logic       tick;
    logic       half_stb;
    half_kind_e half_kind;

    thr_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(track_in), .edge_seen(edge_seen)
    );

    thr_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(edge_seen), .tick(tick)
    );

    thr_interval_timer #(
        .CNT_W(CNT_W), .ONE_MIN(ONE_MIN), .ONE_MAX(ONE_MAX),
        .ZERO_MIN(ZERO_MIN), .ZERO_MAX(ZERO_MAX)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .edge_seen(edge_seen), .tick(tick),
        .half_stb(half_stb), .half_kind(half_kind)
    );

    thr_half_pairer u_pair (
        .clk(clk), .rst_n(rst_n), .half_stb(half_stb), .half_kind(half_kind),
        .bit_valid(bit_valid), .bit_value(bit_value), .err_pulse(err_pulse)
    );

    // R5: two bits are at least two half-"1" intervals apart
    assert_bit_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);

    assert_err_not_with_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_pulse && bit_valid));

endmodule

// File: tb/test_track_halfbit_rx.sv
module test_track_halfbit_rx;
    localparam int unsigned CPU = 10;

    typedef struct packed {
        logic [7:0][8:0] dur;
        logic [3:0]      nbits;
        logic [7:0]      pat;
        logic [3:0]      nerr;
    } vec_t;

    localparam int NVEC = 13;
    // durations in us, first half in the leftmost slot; 0 ends the list
    localparam vec_t VEC [NVEC] = '{
        '{dur: {9'd58, 9'd58, 9'd58, 9'd58, 9'd0, 9'd0, 9'd0, 9'd0},       nbits: 4'd2, pat: 8'b11,  nerr: 4'd1},
        '{dur: {9'd100, 9'd100, 9'd58, 9'd58, 9'd100, 9'd100, 9'd0, 9'd0}, nbits: 4'd3, pat: 8'b010, nerr: 4'd1},
        '{dur: {9'd52, 9'd64, 9'd95, 9'd200, 9'd0, 9'd0, 9'd0, 9'd0},      nbits: 4'd2, pat: 8'b01,  nerr: 4'd1},
        '{dur: {9'd51, 9'd58, 9'd58, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0},        nbits: 4'd1, pat: 8'b1,   nerr: 4'd2},
        '{dur: {9'd65, 9'd58, 9'd58, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0},        nbits: 4'd1, pat: 8'b1,   nerr: 4'd2},
        '{dur: {9'd94, 9'd100, 9'd100, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0},      nbits: 4'd1, pat: 8'b0,   nerr: 4'd2},
        '{dur: {9'd58, 9'd58, 9'd28, 9'd3, 9'd27, 9'd58, 9'd58, 9'd0},     nbits: 4'd2, pat: 8'b11,  nerr: 4'd4},
        '{dur: {9'd58, 9'd58, 9'd58, 9'd100, 9'd100, 9'd58, 9'd58, 9'd0},  nbits: 4'd3, pat: 8'b101, nerr: 4'd2},
        '{dur: {9'd58, 9'd100, 9'd100, 9'd58, 9'd58, 9'd0, 9'd0, 9'd0},    nbits: 4'd2, pat: 8'b10,  nerr: 4'd1},
        '{dur: {9'd58, 9'd58, 9'd250, 9'd58, 9'd58, 9'd0, 9'd0, 9'd0},     nbits: 4'd2, pat: 8'b11,  nerr: 4'd2},
        '{dur: {9'd100, 9'd100, 9'd201, 9'd100, 9'd100, 9'd0, 9'd0, 9'd0}, nbits: 4'd2, pat: 8'b00,  nerr: 4'd2},
        '{dur: {9'd400, 9'd100, 9'd58, 9'd58, 9'd0, 9'd0, 9'd0, 9'd0},     nbits: 4'd1, pat: 8'b1,   nerr: 4'd2},
        '{dur: {9'd58, 9'd58, 9'd58, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0},        nbits: 4'd1, pat: 8'b1,   nerr: 4'd1}
    };
    // requirement exercised by each vector
    localparam string VTAG [NVEC] = '{"R1 R2 R5", "R3 R5", "R2 R3", "R2 R4", "R2 R4", "R3 R4",
                                      "R4", "R6", "R7", "R8", "R8 R3", "R9", "R5"};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic track_in = 1'b0;
    logic bit_valid, bit_value, err_pulse;

    int checks = 0;
    int errors = 0;
    int nb = 0;
    int ne = 0;
    logic bitlog [0:255];
    bit done = 1'b0;

    always #5 clk = ~clk;

    track_halfbit_rx #(.CLK_PER_US(CPU)) i_track_halfbit_rx (
        .clk(clk), .rst_n(rst_n), .track_in(track_in),
        .bit_valid(bit_valid), .bit_value(bit_value), .err_pulse(err_pulse)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (bit_valid) begin
                bitlog[nb[7:0]] = bit_value;
                nb = nb + 1;
            end
            if (err_pulse) ne = ne + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wait_us(input int us);
        repeat (us * CPU) @(negedge clk);
    endtask

    task automatic toggle();
        @(negedge clk);
        track_in = ~track_in;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int b0, e0, gp;
        repeat (10) @(negedge clk);
        // R10: outputs quiet in reset
        check(!bit_valid && !err_pulse, "R10 in reset", int'(bit_valid) + int'(err_pulse), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(!bit_valid && !err_pulse && nb == 0 && ne == 0, "R10 after reset", nb + ne, 0);
        // R8: idle line after reset times out once
        wait_us(260);
        check(ne == 1, "R8 idle timeout", ne, 1);
        check(nb == 0, "R10 no bits from idle", nb, 0);

        for (int v = 0; v < NVEC; v++) begin
            b0 = nb;
            e0 = ne;
            toggle();
            for (int i = 7; i >= 0; i--) begin
                if (VEC[v].dur[i] == 9'd0) break;
                wait_us(int'(VEC[v].dur[i]));
                track_in = ~track_in;
            end
            wait_us(260);
            check(nb - b0 == int'(VEC[v].nbits), $sformatf("%s vec%0d bit count", VTAG[v], v),
                  nb - b0, int'(VEC[v].nbits));
            check(ne - e0 == int'(VEC[v].nerr), $sformatf("%s vec%0d error count", VTAG[v], v),
                  ne - e0, int'(VEC[v].nerr));
            gp = 0;
            for (int k = 0; k < 8; k++)
                if (k < nb - b0 && bitlog[(b0 + k) % 256]) gp = gp | (1 << k);
            check(gp == int'(VEC[v].pat), $sformatf("%s vec%0d bit values", VTAG[v], v),
                  gp, int'(VEC[v].pat));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule